// File: doc/BRIEF.md
# Immediate Floating-Point Constant Loader

This execution unit builds floating-point register constants from 16-bit instruction immediates. It never reads memory, never consults the rounding mode and never updates status flags. It supports two operations, chosen by a one-bit opcode.

The high-load operation (opcode 0) treats the immediate as a bfloat16 value. The immediate becomes the upper half of a single-precision pattern, the lower half is zero, and the pattern is widened to the 64-bit register format.

The low-insert operation (opcode 1) takes a 64-bit register value and narrows it to single precision. It then overwrites the low 16 bits of the single pattern with the immediate and widens the result back to 64 bits. Issuing a high-load and then a low-insert on its result produces any 32-bit single constant with two short instructions.

The unit has one register stage. It accepts one operation per clock, and each result appears on the clock edge after its request.

Top module: `fpimm_loader`

## Requirements
- R1: While reset is asserted (rst_n low), out_vld is 0 and out_res is all zeros.
- R2: out_vld equals the value in_vld had on the previous clock edge. Requests on consecutive cycles each produce a result one cycle later.
- R3: With in_op = 0, the single pattern {in_imm, 16'h0000} is widened. The sign is kept. A normal single exponent e (1..254) becomes the double exponent e + 896. The 23-bit fraction is placed in result bits 51:29.
- R4: A zero single pattern widens to a zero of the same sign, whatever the rounding mode. Immediate 0x0000 with in_op = 0 gives 64'h0, and immediate 0x8000 gives 64'h8000000000000000.
- R5: A single exponent of 255 widens to the double exponent 2047 with the fraction kept, so infinities and NaN payloads pass through.
- R6: A single denormal (exponent 0, fraction nonzero) is normalized during widening. If its fraction has z leading zeros (of 23 bits), the double exponent is 896 - z. The fraction bits below the leading one are left-aligned in bits 51:29.
- R7: With in_op = 1, in_src is narrowed to a 32-bit single pattern. Its low 16 bits are replaced with in_imm, and the pattern is widened by the R3 to R6 rules.
- R8: When narrowing, a source exponent E in 874..896 gives a single denormal. Its fraction is the top 23 fractional bits of {1, source fraction} shifted right by 897 - E, and the shifted-out bits are dropped.
- R9: When narrowing, every other source exponent (including 0, 2047, and values not representable as a single) gives {sign, E[10], E[6:0], source fraction bits 51:29}. No error or status output exists.
- R10: A high-load of immediate H whose result is fed to a low-insert with immediate L gives a value that narrows back to exactly {H, L}.
- R11: On cycles where in_vld is 0, out_res keeps its previous value.
- R12: Result bits 28:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 1 | 0 = bfloat16 high load, 1 = insert into low half |
| in_imm | input | 16 | Immediate value |
| in_src | input | 64 | Register value read by the low-insert operation |
| out_vld | output | 1 | Result strobe |
| out_res | output | 64 | Result in 64-bit register format |

## Verification
Every result, including the valid strobe, is due exactly one rising edge after its request. The bench's reference model therefore registers its prediction on the same edge as the unit. The comparison happens on the following falling edge, so a single-cycle slip in either the strobe or the data is caught. For the round-trip case, the high-load result is read on the falling edge after its request and fed as the source of the next request. Idle cycles between requests are also compared, which checks that the held result does not move.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;

    localparam int SP_W  = 32;
    localparam int SP_E  = 8;
    localparam int SP_F  = 23;
    localparam int DP_W  = 64;
    localparam int DP_E  = 11;
    localparam int DP_F  = 52;
    localparam int IMM_W = 16;

    localparam int SP_BIAS   = (1 << (SP_E - 1)) - 1;
    localparam int DP_BIAS   = (1 << (DP_E - 1)) - 1;
    localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
    localparam int PAD_W     = DP_F - SP_F;
    localparam int DN_HI     = BIAS_DIFF;
    localparam int DN_LO     = BIAS_DIFF - SP_F + 1;

    typedef enum logic {
        OP_LOAD_HI   = 1'b0,
        OP_INSERT_LO = 1'b1
    } fpimm_op_e;

    typedef struct packed {
        logic            vld;
        logic [DP_W-1:0] res;
    } fpimm_state_t;

endpackage

// File: rtl/fpimm_lzc.sv
module fpimm_lzc #(
    parameter int W = 23,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    logic [W:0] clear_above;

    assign clear_above[W] = 1'b1;

    genvar i;
    generate
        for (i = W - 1; i >= 0; i--) begin : g_scan
            assign clear_above[i] = clear_above[i+1] & ~vec[i];
        end
    endgenerate

    always_comb begin
        cnt = '0;
        for (int k = 0; k < W; k++) begin
            cnt = cnt + CW'(clear_above[W-1-k] ? 1 : 0);
        end
    end

endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen
    import fpimm_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp
);

    localparam int LZW = $clog2(SP_F + 1);

    logic              sgn;
    logic [SP_E-1:0]   ex;
    logic [SP_F-1:0]   fr;
    logic [LZW-1:0]    lz;
    logic [SP_F-1:0]   nfr;
    logic [LZW:0]      shamt;
    logic [DP_E-1:0]   dex;

    assign sgn = sp[SP_W-1];
    assign ex  = sp[SP_W-2 -: SP_E];
    assign fr  = sp[SP_F-1:0];

    fpimm_lzc #(.W(SP_F)) u_lzc (
        .vec (fr),
        .cnt (lz)
    );

    always_comb begin
        shamt = {1'b0, lz} + (LZW+1)'(1);
        nfr   = fr << shamt;
        dex   = '0;
        dp    = '0;
        if (ex == '0) begin
            if (fr == '0) begin
                dp = {sgn, {(DP_W-1){1'b0}}};
            end else begin
                dex = DP_E'(BIAS_DIFF) - DP_E'(lz);
                dp  = {sgn, dex, nfr, {PAD_W{1'b0}}};
            end
        end else if (ex == '1) begin
            dp = {sgn, {DP_E{1'b1}}, fr, {PAD_W{1'b0}}};
        end else begin
            dex = DP_E'(ex) + DP_E'(BIAS_DIFF);
            dp  = {sgn, dex, fr, {PAD_W{1'b0}}};
        end
    end

endmodule

// File: rtl/fpimm_narrow.sv
module fpimm_narrow
    import fpimm_pkg::*;
(
    input  logic [DP_W-1:0] dp,
    output logic [SP_W-1:0] sp
);

    logic            sgn;
    logic [DP_E-1:0] ex;
    logic [DP_F-1:0] fr;
    logic [DP_F:0]   mant;
    logic [DP_F:0]   shifted;
    logic [DP_E-1:0] shamt;
    logic            in_dn;

    assign sgn  = dp[DP_W-1];
    assign ex   = dp[DP_W-2 -: DP_E];
    assign fr   = dp[DP_F-1:0];
    assign mant = {1'b1, fr};

    always_comb begin
        in_dn   = (ex >= DP_E'(DN_LO)) && (ex <= DP_E'(DN_HI));
        shamt   = DP_E'(DN_HI + 1) - ex;
        shifted = mant >> shamt;
        if (in_dn) begin
            sp = {sgn, {SP_E{1'b0}}, shifted[DP_F-1 -: SP_F]};
        end else begin
            sp = {sgn, ex[DP_E-1], ex[SP_E-2:0], fr[DP_F-1 -: SP_F]};
        end
    end

endmodule

// File: rtl/fpimm_loader.sv
module fpimm_loader
    import fpimm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_op,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [DP_W-1:0]  in_src,
    output logic             out_vld,
    output logic [DP_W-1:0]  out_res
);

    fpimm_state_t    st_d, st_q;
    fpimm_op_e       op;
    logic [SP_W-1:0] src_sp;
    logic [SP_W-1:0] pat_sp;
    logic [DP_W-1:0] pat_dp;

    assign op = fpimm_op_e'(in_op);

    fpimm_narrow u_narrow (
        .dp (in_src),
        .sp (src_sp)
    );

    always_comb begin
        if (op == OP_INSERT_LO) begin
            pat_sp = {src_sp[SP_W-1:IMM_W], in_imm};
        end else begin
            pat_sp = {in_imm, {(SP_W-IMM_W){1'b0}}};
        end
    end

    fpimm_widen u_widen (
        .sp (pat_sp),
        .dp (pat_dp)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.res = pat_dp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_res = st_q.res;

endmodule

// File: rtl/fpimm_loader_chk.sv
module fpimm_loader_chk
    import fpimm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             in_op,
    input logic [IMM_W-1:0] in_imm,
    input logic [DP_W-1:0]  in_src,
    input logic             out_vld,
    input logic [DP_W-1:0]  out_res
);

    a_r2_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_res[DP_W-1] == $past(in_op ? in_src[DP_W-1] : in_imm[IMM_W-1]));

    a_r4_signed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_op && in_imm[IMM_W-2:0] == '0)
        |=> out_res == {$past(in_imm[IMM_W-1]), {(DP_W-1){1'b0}}});

    a_r5_special_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_op && in_imm[IMM_W-2 -: SP_E] == '1)
        |=> out_res[DP_W-2 -: DP_E] == '1);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_res));

    a_r12_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_res[PAD_W-1:0] == '0);

endmodule

bind fpimm_loader fpimm_loader_chk u_chk (.*);

// File: tb/sim_fpimm_loader.sv
module sim_fpimm_loader;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic        in_op;
    logic [15:0] in_imm;
    logic [63:0] in_src;
    logic        out_vld;
    logic [63:0] out_res;

    always #4 clk = ~clk;

    fpimm_loader u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_imm(in_imm), .in_src(in_src), .out_vld(out_vld), .out_res(out_res)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R3";

    logic        m_vld;
    logic [63:0] m_res;
    string       m_tag;

    function automatic logic [63:0] f_widen(input logic [31:0] s);
        int          e;
        logic [23:0] m;
        e = int'(s[30:23]);
        if (e == 0 && s[22:0] == 23'h0) return {s[31], 63'h0};
        if (e == 255) return {s[31], 11'h7ff, s[22:0], 29'h0};
        if (e != 0) return {s[31], 11'(e + 896), s[22:0], 29'h0};
        m = {1'b0, s[22:0]};
        e = 897;
        while (!m[23]) begin
            m = m << 1;
            e = e - 1;
        end
        return {s[31], 11'(e), m[22:0], 29'h0};
    endfunction

    function automatic logic [31:0] f_narrow(input logic [63:0] d);
        int          e;
        logic [52:0] m;
        e = int'(d[62:52]);
        if (e >= 874 && e <= 896) begin
            m = {1'b1, d[51:0]};
            for (int k = 0; k < 897 - e; k++) m = m >> 1;
            return {d[63], 8'h0, m[51:29]};
        end
        return {d[63], d[62], d[58:52], d[51:29]};
    endfunction

    function automatic logic [63:0] f_expect(input logic op, input logic [15:0] imm,
                                             input logic [63:0] src);
        logic [31:0] n;
        n = f_narrow(src);
        if (op) return f_widen({n[31:16], imm});
        return f_widen({imm, 16'h0});
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vld <= 1'b0;
            m_res <= 64'h0;
            m_tag <= "R1";
        end else begin
            m_vld <= in_vld;
            if (in_vld) m_res <= f_expect(in_op, in_imm, in_src);
            m_tag <= in_vld ? cur_tag : "R11";
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && rst_n && !done) begin
            chk("R2", {63'h0, out_vld}, {63'h0, m_vld});
            chk(m_tag, out_res, m_res);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic issue(input logic op, input logic [15:0] imm, input logic [63:0] src,
                         input string tag);
        @(negedge clk);
        in_vld  = 1'b1;
        in_op   = op;
        in_imm  = imm;
        in_src  = src;
        cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_imm = 16'hdead;
            in_src = 64'hffff_0000_ffff_0000;
        end
    endtask

    task automatic round_trip(input logic [15:0] hi, input logic [15:0] lo);
        logic [63:0] mid;
        issue(1'b0, hi, 64'h0, "R10");
        idle(1);
        mid = out_res;
        issue(1'b1, lo, mid, "R10");
        idle(1);
        chk("R10", {32'h0, f_narrow(out_res)}, {32'h0, hi, lo});
        chk("R10", out_res, f_widen({hi, lo}));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n  = 1'b0;
        in_vld = 1'b1;
        in_op  = 1'b0;
        in_imm = 16'h3f80;
        in_src = 64'h0;
        repeat (3) @(negedge clk);
        chk("R1", {63'h0, out_vld}, 64'h0);
        chk("R1", out_res, 64'h0);
        in_vld = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        chk_en = 1'b1;

        // R3 normal bfloat16 values, back to back
        issue(1'b0, 16'h3f80, 64'h0, "R3");
        issue(1'b0, 16'hc049, 64'h0, "R3");
        issue(1'b0, 16'h0080, 64'h0, "R3");
        // R4 signed zeros
        issue(1'b0, 16'h0000, 64'h0, "R4");
        issue(1'b0, 16'h8000, 64'h0, "R4");
        idle(2);
        // R5 infinity and NaN
        issue(1'b0, 16'h7f80, 64'h0, "R5");
        issue(1'b0, 16'hff80, 64'h0, "R5");
        issue(1'b0, 16'h7fc1, 64'h0, "R5");
        // R6 denormal widening from both opcodes
        issue(1'b0, 16'h0040, 64'h0, "R6");
        issue(1'b0, 16'h8001, 64'h0, "R6");
        issue(1'b1, 16'h0001, 64'h0, "R6");
        issue(1'b1, 16'h0000, 64'h0, "R4");
        idle(1);
        // R7 insert into normal values
        issue(1'b1, 16'h1234, 64'h3ff0_0000_0000_0000, "R7");
        issue(1'b1, 16'hffff, 64'hc009_21fb_5444_2d18, "R7");
        issue(1'b1, 16'h0bad, 64'h7ff0_0000_0000_0000, "R7");
        // R8 source in single denormal exponent range
        issue(1'b1, 16'h0000, {1'b0, 11'd880, 52'h8_0000_0000_0001}, "R8");
        issue(1'b1, 16'h5555, {1'b1, 11'd896, 52'hf_ffff_ffff_ffff}, "R8");
        issue(1'b1, 16'h0001, {1'b0, 11'd874, 52'h0}, "R8");
        // R9 unrepresentable sources
        issue(1'b1, 16'habcd, 64'h0080_0000_0000_0001, "R9");
        issue(1'b1, 16'h0000, {1'b0, 11'd873, 52'hf_0000_0000_0000}, "R9");
        issue(1'b1, 16'h4321, {1'b0, 11'h7fe, 52'h1_2345_6789_abcd}, "R9");
        issue(1'b1, 16'h0002, 64'hfff8_0000_0000_0000, "R9");
        idle(3);
        // R10 round trips
        round_trip(16'h4049, 16'h0fdb);
        round_trip(16'h0000, 16'h0003);
        round_trip(16'hff80, 16'h0001);
        round_trip(16'h0040, 16'h8000);
        idle(2);
        finish_run();
    end

endmodule